// File: doc/BRIEF.md
# Streaming Micro-Price Feature Extractor

This block turns a stream of top-of-book snapshots into two trading features per snapshot. Each input beat holds the best bid price, the best ask price and the quantity resting at each of the two. The matching output beat holds two values:

- a size-weighted micro-price, which pulls the price toward the ask when bid size dominates;
- a signed volume imbalance.

Both outputs use a fixed-point format with 16 fractional bits.

The two ratios the features need are formed by shift-and-subtract fractional dividers, with one quotient bit per pipeline stage. Both datapaths therefore have the same fixed latency, and the block takes a new beat every clock.

Both sides are ready/valid streams. The input beat is 128 bits wide and the output beat is 64 bits wide. A last flag rides with each beat. When the consumer stalls, the whole pipeline freezes and the input ready drops, so nothing is lost.

Top module: `fx_micro_feature`

## Requirements
- R1: The input beat packs bid price in bits [31:0], ask price in [63:32], bid quantity in [95:64] and ask quantity in [127:96], all unsigned. The output beat packs micro-price in [31:0] and imbalance in [63:32]. While the output ready stays high, the input ready stays high, so one beat is taken every cycle.
- R2: With S = bidQty + askQty (33-bit) nonzero, the weight is w = floor(bidQty·65536/S). The micro-price output is the low 32 bits of bid·65536 + (ask − bid)·w, where the price difference is signed.
- R3: With S nonzero, the imbalance magnitude is floor(|bidQty − askQty|·65536/S). It is output as a 32-bit two's complement value that is negative when bidQty < askQty, so it always lies within ±65536.
- R4: When askQty is 0 and bidQty is nonzero, the micro-price is ask·65536 and the imbalance is +65536. When bidQty is 0 and askQty is nonzero, the micro-price is bid·65536 and the imbalance is −65536.
- R5: When both quantities are 0, the micro-price is the mid, (bid + ask)·32768 in its low 32 bits, and the imbalance is 0.
- R6: Take the cycle in which a beat is accepted with the output ready held high. Its result first shows output valid 19 cycles later (FRAC + 3).
- R7: The last flag of each input beat appears on the output together with that beat's features. The output last flag is never high without output valid.
- R8: While output valid is high and output ready is low:
  - the output data, valid and last hold their values into the next cycle;
  - input ready is low.
  No beat is dropped, duplicated or reordered.
- R9: After reset, output valid is low and input ready is high. Beats in flight when reset is asserted are discarded and never appear at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inTdata | input | 128 | Book snapshot: prices and quantities |
| inTvalid | input | 1 | Input beat valid |
| inTready | output | 1 | Block can take an input beat |
| inTlast | input | 1 | Last flag of the input beat |
| outTdata | output | 64 | Imbalance (upper half) and micro-price (lower half) |
| outTvalid | output | 1 | Output beat valid |
| outTready | input | 1 | Consumer takes the output beat |
| outTlast | output | 1 | Last flag carried from the matching input beat |

## Verification
Corrupt divider state, such as a wrong remainder or a misaligned quotient bit, shows as a wrong low-order fraction on the very next beat to leave the pipeline, 19 cycles after it entered. A side register that slips against its quotient would pair one beat's prices with another beat's weight, and the micro-price of consecutive distinct vectors exposes that at once. A broken stall path shows up within one cycle of a deasserted output ready, either as changed output data or as a beat missing from the in-order sequence. Quantity extremes and zero-sum and one-sided books exercise the quotient bit with the integer weight and the override paths.

// File: rtl/fx_feat_pkg.sv
package fx_feat_pkg;
  // Strobes from the pipeline control to the datapath.
  typedef struct packed {
    logic advance;  // every pipeline register moves one stage
    logic accept;   // a new beat enters the first stage
  } fx_strobe_t;
endpackage

// File: rtl/fx_frac_div.sv
// Pipelined restoring divider producing floor(num * 2^(QBITS-1) / den).
// One quotient bit per stage, most significant (integer) bit first.
module fx_frac_div #(
  parameter int NUM_W = 33,
  parameter int QBITS = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [NUM_W-1:0] num,
  input  logic [NUM_W-1:0] den,
  output logic [QBITS-1:0] quo
);
  localparam int REM_W = NUM_W + 1;

  for (genvar k = 0; k < QBITS; k++) begin : g_stage
    logic [REM_W-1:0] remIn, trial, remQ;
    logic [NUM_W-1:0] denIn, denQ;
    logic [QBITS-1:0] quoIn, quoQ;
    logic             ge;

    if (k == 0) begin : g_first
      assign remIn = {1'b0, num};
      assign denIn = den;
      assign quoIn = '0;
      assign trial = remIn;
    end else begin : g_next
      assign remIn = g_stage[k-1].remQ;
      assign denIn = g_stage[k-1].denQ;
      assign quoIn = g_stage[k-1].quoQ;
      assign trial = remIn << 1;
    end

    assign ge = trial >= {1'b0, denIn};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        remQ <= '0;
        denQ <= '0;
        quoQ <= '0;
      end else if (en) begin
        remQ <= ge ? (trial - {1'b0, denIn}) : trial;
        denQ <= denIn;
        quoQ <= {quoIn[QBITS-2:0], ge};
      end
    end
  end

  logic [REM_W-1:0] remLast;
  logic [NUM_W-1:0] denLast;
  assign quo     = g_stage[QBITS-1].quoQ;
  assign remLast = g_stage[QBITS-1].remQ;
  assign denLast = g_stage[QBITS-1].denQ;

  // R2: operands never exceed the divisor, so the quotient is at most 1.0
  assert_quo_range_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (denLast != '0) |-> (quo <= (QBITS'(1) << (QBITS-1))));

  // R2: the final partial remainder stays below the divisor
  assert_rem_bound_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (denLast != '0) |-> (remLast < {1'b0, denLast}));
endmodule

// File: rtl/fx_feat_datapath.sv
module fx_feat_datapath
  import fx_feat_pkg::*;
#(
  parameter int FIELD_W = 32,
  parameter int FRAC    = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fx_strobe_t             strobe,
  input  logic [4*FIELD_W-1:0]   inData,
  output logic [2*FIELD_W-1:0]   outData
);
  localparam int NUM_W  = FIELD_W + 1;
  localparam int QBITS  = FRAC + 1;
  localparam int SIDE_W = 2 * FIELD_W + 2;
  localparam int PROD_W = FIELD_W + FRAC + 3;
  localparam int LANES  = 2;

  // ---------------- entry stage ----------------
  logic [FIELD_W-1:0] bidR, askR, bidQtyR, askQtyR;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bidR    <= '0;
      askR    <= '0;
      bidQtyR <= '0;
      askQtyR <= '0;
    end else if (strobe.accept) begin
      bidR    <= inData[0*FIELD_W +: FIELD_W];
      askR    <= inData[1*FIELD_W +: FIELD_W];
      bidQtyR <= inData[2*FIELD_W +: FIELD_W];
      askQtyR <= inData[3*FIELD_W +: FIELD_W];
    end
  end

  logic [NUM_W-1:0]   qtySum;
  logic [FIELD_W-1:0] qtyGap;
  logic               bidHeavy, zeroSum;
  assign qtySum   = NUM_W'(bidQtyR) + NUM_W'(askQtyR);
  assign bidHeavy = bidQtyR >= askQtyR;
  assign qtyGap   = bidHeavy ? (bidQtyR - askQtyR) : (askQtyR - bidQtyR);
  assign zeroSum  = (qtySum == '0);

  // ---------------- two divider lanes: weight and imbalance ----------------
  logic [NUM_W-1:0] laneNum [LANES];
  logic [QBITS-1:0] laneQuo [LANES];
  assign laneNum[0] = {1'b0, bidQtyR};
  assign laneNum[1] = {1'b0, qtyGap};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    fx_frac_div #(.NUM_W(NUM_W), .QBITS(QBITS)) u_div (
      .clk  (clk),
      .rstN (rstN),
      .en   (strobe.advance),
      .num  (laneNum[l]),
      .den  (qtySum),
      .quo  (laneQuo[l])
    );
  end

  // ---------------- side data travelling beside the dividers ----------------
  for (genvar k = 0; k < QBITS; k++) begin : g_side
    logic [SIDE_W-1:0] sideIn, sideQ;
    if (k == 0) begin : g_head
      assign sideIn = {bidR, askR, !bidHeavy, zeroSum};
    end else begin : g_body
      assign sideIn = g_side[k-1].sideQ;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               sideQ <= '0;
      else if (strobe.advance) sideQ <= sideIn;
    end
  end

  logic [SIDE_W-1:0]  sideLast;
  logic [FIELD_W-1:0] bidL, askL;
  logic               negL, zeroL;
  assign sideLast = g_side[QBITS-1].sideQ;
  assign bidL     = sideLast[SIDE_W-1 -: FIELD_W];
  assign askL     = sideLast[2 +: FIELD_W];
  assign negL     = sideLast[1];
  assign zeroL    = sideLast[0];

  // ---------------- feature assembly ----------------
  logic [QBITS-1:0]          weight;
  logic signed [FIELD_W:0]   priceDiff;
  logic signed [PROD_W-1:0]  prod;
  logic [PROD_W-1:0]         microFull;
  logic [FIELD_W-1:0]        imbMag, imbOut;

  assign weight    = zeroL ? (QBITS'(1) << (FRAC - 1)) : laneQuo[0];
  assign priceDiff = $signed({1'b0, askL}) - $signed({1'b0, bidL});
  assign prod      = PROD_W'(priceDiff) * $signed({{(PROD_W-QBITS){1'b0}}, weight});
  assign microFull = $unsigned(prod) + ({{(PROD_W-FIELD_W){1'b0}}, bidL} << FRAC);
  assign imbMag    = zeroL ? '0 : FIELD_W'(laneQuo[1]);
  assign imbOut    = negL ? ((~imbMag) + 1'b1) : imbMag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               outData <= '0;
    else if (strobe.advance) outData <= {imbOut, microFull[FIELD_W-1:0]};
  end
endmodule

// File: rtl/fx_feat_control.sv
module fx_feat_control
  import fx_feat_pkg::*;
#(
  parameter int LAT = 19
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inLast,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output logic       outLast,
  output fx_strobe_t strobe
);
  logic [LAT-1:0] vldQ, lstQ;
  logic           advance;

  assign advance        = outReady || !vldQ[LAT-1];
  assign inReady        = advance;
  assign strobe.advance = advance;
  assign strobe.accept  = advance && inValid;
  assign outValid       = vldQ[LAT-1];
  assign outLast        = lstQ[LAT-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldQ <= '0;
      lstQ <= '0;
    end else if (advance) begin
      vldQ <= {vldQ[LAT-2:0], inValid};
      lstQ <= {lstQ[LAT-2:0], inValid && inLast};
    end
  end

  // R7: a last flag only ever travels with a valid beat
  assert_last_with_valid_R7 : assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R8: a refused output beat is still offered, with the same last flag
  assert_hold_valid_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outLast)));
endmodule

// File: rtl/fx_micro_feature.sv
module fx_micro_feature
  import fx_feat_pkg::*;
#(
  parameter int FIELD_W = 32,
  parameter int FRAC    = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [4*FIELD_W-1:0] inTdata,
  input  logic                 inTvalid,
  output logic                 inTready,
  input  logic                 inTlast,
  output logic [2*FIELD_W-1:0] outTdata,
  output logic                 outTvalid,
  input  logic                 outTready,
  output logic                 outTlast
);
  localparam int LAT = FRAC + 3;  // entry + one stage per quotient bit + output

  fx_strobe_t strobe;

  fx_feat_control #(.LAT(LAT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inTvalid),
    .inLast   (inTlast),
    .outReady (outTready),
    .inReady  (inTready),
    .outValid (outTvalid),
    .outLast  (outTlast),
    .strobe   (strobe)
  );

  fx_feat_datapath #(.FIELD_W(FIELD_W), .FRAC(FRAC)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inData  (inTdata),
    .outData (outTdata)
  );

  localparam int signed ONE_Q = 1 << FRAC;
  logic signed [FIELD_W-1:0] imbField;
  assign imbField = $signed(outTdata[2*FIELD_W-1 -: FIELD_W]);

  // R8: output data is frozen while the consumer refuses it
  assert_data_hold_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (outTvalid && !outTready) |=> $stable(outTdata));

  // R3: imbalance never leaves the range -1.0 .. +1.0
  assert_imb_range_R3 : assert property (@(posedge clk) disable iff (!rstN)
    outTvalid |-> ((imbField <= ONE_Q) && (imbField >= -ONE_Q)));
endmodule

// File: tb/fx_micro_feature_tb_top.sv
`timescale 1ns/1ps
module fx_micro_feature_tb_top;
  localparam int FIELD_W = 32;
  localparam int FRAC    = 16;
  localparam int LAT     = FRAC + 3;
  localparam int NVEC    = 16;
  localparam int MAXB    = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [127:0] inTdata = '0;
  logic         inTvalid = 1'b0, inTlast = 1'b0, inTready;
  logic [63:0]  outTdata;
  logic         outTvalid, outTlast;
  logic         outTready = 1'b1;

  fx_micro_feature #(.FIELD_W(FIELD_W), .FRAC(FRAC)) dut_i (
    .clk(clk), .rstN(rstN),
    .inTdata(inTdata), .inTvalid(inTvalid), .inTready(inTready), .inTlast(inTlast),
    .outTdata(outTdata), .outTvalid(outTvalid), .outTready(outTready), .outTlast(outTlast)
  );

  // {askQty, bidQty, ask, bid}
  localparam logic [127:0] VEC [NVEC] = '{
    {32'd30,         32'd10,         32'd1001,  32'd1000},
    {32'd10,         32'd30,         32'd1001,  32'd1000},
    {32'd7,          32'd7,          32'd1002,  32'd1000},
    {32'd2,          32'd1,          32'd510,   32'd500},
    {32'd678,        32'd12345,      32'd103,   32'd100},
    {32'hFFFFFFFF,   32'hFFFFFFFF,   32'd2001,  32'd2000},
    {32'd1,          32'hFFFFFFFF,   32'd2001,  32'd2000},
    {32'hFFFFFFFF,   32'd1,          32'd3005,  32'd3000},
    {32'd9,          32'd5,          32'd42,    32'd42},
    {32'd5,          32'd3,          32'd1190,  32'd1200},
    {32'd0,          32'd100,        32'd9,     32'd7},
    {32'd100,        32'd0,          32'd9,     32'd7},
    {32'd0,          32'd0,          32'd301,   32'd300},
    {32'd65537,      32'd65535,      32'd30001, 32'd30000},
    {32'd1000000,    32'd3,          32'd2,     32'd1},
    {32'd4,          32'd9,          32'd60010, 32'd60000}
  };

  logic [31:0] expMp [MAXB];
  logic [31:0] expImb [MAXB];
  logic        expLast [MAXB];
  string       tagMp [MAXB];
  string       tagImb [MAXB];

  int sndIdx = 0, rcvIdx = 0, checks = 0, errors = 0;
  int readyMode = 0, retries = 0, stallSeen = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic        stalled = 1'b0;
  logic [65:0] held = '0;

  function automatic logic [63:0] model(input logic [127:0] d);
    longint bid, ask, bq, aq, sum, w, mag, mp, imb;
    bid = longint'(d[31:0]);  ask = longint'(d[63:32]);
    bq  = longint'(d[95:64]); aq  = longint'(d[127:96]);
    sum = bq + aq;
    if (sum == 0) begin
      mp  = (bid + ask) * 32768;
      imb = 0;
    end else begin
      w   = (bq * 65536) / sum;
      mag = (((bq > aq) ? (bq - aq) : (aq - bq)) * 65536) / sum;
      mp  = bid * 65536 + (ask - bid) * w;
      imb = (bq < aq) ? -mag : mag;
    end
    return {imb[31:0], mp[31:0]};
  endfunction

  task automatic check(input string tag, input string what, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor and output-ready driver; runs on falling edges.
  always @(negedge clk) begin
    logic nextReady;
    if (readyMode == 0) nextReady = 1'b1;
    else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      nextReady = lfsr[0] & (lfsr[1] | lfsr[2]);
    end
    if (rstN) begin
      if (stalled) begin
        stallSeen++;
        check("R8", "held beat", {outTvalid, outTlast, outTdata}, held);
      end
      if (outTvalid && nextReady) begin
        if (rcvIdx >= sndIdx) begin
          check("R8", "unexpected beat", {outTvalid, outTlast, outTdata}, 66'd0);
        end else begin
          check(tagMp[rcvIdx], "micro-price", {34'd0, outTdata[31:0]}, {34'd0, expMp[rcvIdx]});
          check(tagImb[rcvIdx], "imbalance", {34'd0, outTdata[63:32]}, {34'd0, expImb[rcvIdx]});
          check("R7", "last flag", {65'd0, outTlast}, {65'd0, expLast[rcvIdx]});
          rcvIdx++;
        end
      end
      stalled = outTvalid && !nextReady;
      held = {outTvalid, outTlast, outTdata};
    end else begin
      stalled = 1'b0;
    end
    outTready = nextReady;
  end

  task automatic sendBeat(input logic [127:0] d, input logic last, input string tM, input string tI);
    logic [63:0] e;
    logic acc;
    @(negedge clk);
    e = model(d);
    expMp[sndIdx] = e[31:0]; expImb[sndIdx] = e[63:32]; expLast[sndIdx] = last;
    tagMp[sndIdx] = tM; tagImb[sndIdx] = tI;
    sndIdx++;
    inTdata = d; inTlast = last; inTvalid = 1'b1;
    forever begin
      #1;
      acc = inTready;
      if (outTvalid && !outTready) check("R8", "input ready during stall", {65'd0, inTready}, 66'd0);
      @(posedge clk);
      if (acc) break;
      retries++;
      @(negedge clk);
    end
    #1 inTvalid = 1'b0; inTlast = 1'b0;
  endtask

  task automatic drain(input string tag);
    int guard = 0;
    while (rcvIdx < sndIdx && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    check(tag, "all beats delivered", 66'(rcvIdx), 66'(sndIdx));
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL R6 watchdog expired: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    int sawValid;
    logic [127:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk); #1 rstN = 1'b1;
    @(negedge clk); #1;
    // R9: reset state
    check("R9", "valid after reset", {65'd0, outTvalid}, 66'd0);
    check("R9", "ready after reset", {65'd0, inTready}, 66'd1);

    // Vector table, back to back (R1..R5, R7)
    readyMode = 0;
    retries = 0;
    for (int i = 0; i < NVEC; i++) begin
      sendBeat(VEC[i], i == NVEC - 1,
               (i == 10 || i == 11) ? "R4" : (i == 12) ? "R5" : "R2",
               (i == 10 || i == 11) ? "R4" : (i == 12) ? "R5" : "R3");
    end
    check("R1", "one beat per cycle, refusals", 66'(retries), 66'd0);
    drain("R1");

    // R6: latency of an isolated beat
    sendBeat({32'd40, 32'd60, 32'd1234, 32'd1230}, 1'b1, "R6", "R6");
    lat = 0;
    while (lat < 60) begin
      @(negedge clk);
      lat++;
      if (outTvalid) break;
    end
    check("R6", "cycles to output", 66'(lat), 66'(LAT));
    drain("R6");

    // R8: random backpressure with gaps on the input side
    readyMode = 1;
    stallSeen = 0;
    for (int i = 0; i < 24; i++) begin
      d[31:0]   = 32'(1000 + i * 3);
      d[63:32]  = 32'(1001 + i * 3 + (i % 4));
      d[95:64]  = (i % 6 == 0) ? 32'd0 : 32'((i * 977) % 5000);
      d[127:96] = (i % 6 == 0 && i % 12 != 0) ? 32'd0 : 32'((i * 613 + 11) % 7000);
      sendBeat(d, (i % 5) == 4, "R8", "R8");
      if (i % 7 == 3) repeat (3) @(negedge clk);
    end
    drain("R8");
    check("R8", "stall cycles exercised", {65'd0, stallSeen > 0}, 66'd1);

    // R9: reset with beats in flight
    readyMode = 0;
    for (int i = 0; i < 3; i++) sendBeat({32'd5, 32'd6, 32'd77, 32'd70}, 1'b0, "R9", "R9");
    @(negedge clk); #1 rstN = 1'b0;
    rcvIdx = sndIdx;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    sawValid = 0;
    for (int i = 0; i < LAT + 10; i++) begin
      @(negedge clk);
      if (outTvalid) sawValid++;
    end
    check("R9", "discarded beats seen", 66'(sawValid), 66'd0);
    sendBeat({32'd3, 32'd9, 32'd502, 32'd500}, 1'b1, "R9", "R9");
    drain("R9");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule